// File: doc/BRIEF.md
# Capability-Bounded Address Translator

This block sits in front of the load/store and fetch path of a core that guards memory with capabilities. Each ordinary access arrives with a plain 64-bit address, an access kind (fetch, load or store) and a width code. The block adds the offset of a fixed default capability to that address. It then checks the capability's validity tag, its sealed state, the permission that the access kind needs and both ends of its bounds. It returns the translated virtual address or a single prioritised fault.

The fields of the default capability come in on ports from a register file that lives elsewhere. Results are registered. A response appears one clock after a request, with a valid flag, the translated address, a fault flag, a cause code and the index of the capability that performed the check. The check runs on the unwrapped sum of offset, address and size, so an access cannot slip through its bounds by wrapping past the top of the address space.

Top module: `cap_addr_xlate`

## Requirements
- R1: `rsp_valid` is high exactly one clock after a cycle with `req_valid` high and low otherwise. While no request arrives, `rsp_vaddr`, `rsp_exc`, `rsp_cause` and `rsp_capidx` keep their last values, whatever the other inputs do.
- R2: A request with `cap_tag` low faults with cause 1 (tag).
- R3: A request with a set tag and `cap_sealed` high faults with cause 2 (seal).
- R4: The permission checked depends on `req_kind`. For 00 (fetch), a clear `cap_perm_exec` gives cause 3. For 01 (load), a clear `cap_perm_load` gives cause 4. For 10 and 11 (both store), a clear `cap_perm_store` gives cause 5. A permission that the kind does not use has no effect.
- R5: When no check fails, `rsp_exc` is 0, `rsp_cause` is 0 and `rsp_vaddr` equals (`cap_cursor` + `req_addr`) modulo 2^64.
- R6: `req_width` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Let the virtual address be v, the unwrapped sum `cap_cursor` + `req_addr`. The request faults with cause 6 (length) when v + size is greater than `cap_base` + `cap_length`, also taken without wrap. An access that ends exactly at that limit passes.
- R7: The request faults with cause 6 when v is below `cap_base`. The case v equal to `cap_base` passes.
- R8: The request faults with cause 6 when v + size is greater than 2^64, even if the capability limit lies beyond 2^64.
- R9: Only one cause is reported, chosen in the priority order tag, seal, permission, length.
- R10: On a fault, `rsp_exc` is 1, `rsp_vaddr` is 0 and `rsp_capidx` is the default capability index (0). On success, `rsp_capidx` is 0.
- R11: During reset and until the first request, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Untranslated address |
| req_kind | input | 2 | 00 fetch, 01 load, 10/11 store |
| req_width | input | 2 | Size code: 1, 2, 4 or 8 bytes |
| cap_tag | input | 1 | Default capability validity tag |
| cap_sealed | input | 1 | Default capability is sealed |
| cap_perm_exec | input | 1 | Execute permission |
| cap_perm_load | input | 1 | Load permission |
| cap_perm_store | input | 1 | Store permission |
| cap_base | input | 64 | Lower bound |
| cap_length | input | 64 | Size of the region |
| cap_cursor | input | 64 | Offset added to every address |
| rsp_valid | output | 1 | Response present |
| rsp_vaddr | output | 64 | Translated address, 0 on fault |
| rsp_exc | output | 1 | Fault raised |
| rsp_cause | output | 3 | 0 none, 1 tag, 2 seal, 3 exec, 4 load, 5 store, 6 length |
| rsp_capidx | output | 5 | Index of the checking capability on fault |

## Verification
The bench probes the access that ends exactly at base plus length, and the one that ends one byte past it. A design that used the wrong comparison would reject the first or accept the second. It places the virtual address one byte below the base and exactly at it, which catches an off-by-one lower bound. Some accesses have a capability limit above 2^64 and an end just beyond 2^64. A 64-bit wrapping adder would accept these, or compare them against a wrapped limit. Requests that fail several checks at once expose a priority chain in the wrong order. Store-kind code 11 and stores that hold only load permission catch a permission mux that selects the wrong bit.

// File: rtl/cax_pkg.sv
package cax_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH     = 2'b00,
    ACC_LOAD      = 2'b01,
    ACC_STORE     = 2'b10,
    ACC_STORE_ALT = 2'b11
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_TAG    = 3'd1,
    CAUSE_SEAL   = 3'd2,
    CAUSE_EXEC   = 3'd3,
    CAUSE_LOAD   = 3'd4,
    CAUSE_STORE  = 3'd5,
    CAUSE_LENGTH = 3'd6
  } cause_e;

  localparam int unsigned SIZE_W = 4;

  // Width code n selects 2^n bytes.
  function automatic logic [SIZE_W-1:0] width_bytes(input logic [1:0] code);
    return SIZE_W'(1) << code;
  endfunction

endpackage

// File: rtl/cax_rst_sync.sv
module cax_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cax_gate_check.sv
// Tag, seal and per-kind permission screening, in priority order.
module cax_gate_check
  import cax_pkg::*;
(
  input  logic       cap_tag,
  input  logic       cap_sealed,
  input  logic       cap_perm_exec,
  input  logic       cap_perm_load,
  input  logic       cap_perm_store,
  input  logic [1:0] req_kind,
  output logic [2:0] gate_cause
);

  logic       perm_ok;
  logic [2:0] perm_cause;

  always_comb begin
    case (req_kind)
      ACC_FETCH: begin
        perm_ok    = cap_perm_exec;
        perm_cause = CAUSE_EXEC;
      end
      ACC_LOAD: begin
        perm_ok    = cap_perm_load;
        perm_cause = CAUSE_LOAD;
      end
      default: begin
        perm_ok    = cap_perm_store;
        perm_cause = CAUSE_STORE;
      end
    endcase
  end

  always_comb begin
    if (!cap_tag) begin
      gate_cause = CAUSE_TAG;
    end else if (cap_sealed) begin
      gate_cause = CAUSE_SEAL;
    end else if (!perm_ok) begin
      gate_cause = perm_cause;
    end else begin
      gate_cause = CAUSE_NONE;
    end
  end

endmodule

// File: rtl/cax_bounds_check.sv
// Offset addition and two-ended bounds test on unwrapped sums.
module cax_bounds_check
  import cax_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_width,
  input  logic [AW-1:0]     cap_base,
  input  logic [AW-1:0]     cap_length,
  input  logic [AW-1:0]     cap_cursor,
  output logic [AW-1:0]     virt_addr,
  output logic              bound_fault
);

  // Two guard bits: the offset sum can reach 2^(AW+1)-2 before the size is added.
  localparam int unsigned SW = AW + 2;

  logic [SW-1:0]     v_full;
  logic [SW-1:0]     v_end;
  logic [SW-1:0]     v_limit;
  logic [SW-1:0]     v_floor;
  logic [SW-1:0]     v_space;
  logic [SIZE_W-1:0] acc_size;
  logic              over_limit;
  logic              under_base;
  logic              over_space;

  always_comb begin
    acc_size   = width_bytes(req_width);
    v_full     = {2'b00, cap_cursor} + {2'b00, req_addr};
    v_end      = v_full + SW'(acc_size);
    v_floor    = {2'b00, cap_base};
    v_limit    = v_floor + {2'b00, cap_length};
    v_space    = SW'(1) << AW;
    over_limit = v_end > v_limit;
    under_base = v_full < v_floor;
    over_space = v_end > v_space;
    bound_fault = over_limit | under_base | over_space;
    virt_addr  = v_full[AW-1:0];
  end

endmodule

// File: rtl/cap_addr_xlate.sv
module cap_addr_xlate
  import cax_pkg::*;
#(
  parameter int unsigned AW          = 64,
  parameter int unsigned CAPIDX_W    = 5,
  parameter int unsigned DEF_CAP_IDX = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_addr,
  input  logic [1:0]          req_kind,
  input  logic [1:0]          req_width,
  input  logic                cap_tag,
  input  logic                cap_sealed,
  input  logic                cap_perm_exec,
  input  logic                cap_perm_load,
  input  logic                cap_perm_store,
  input  logic [AW-1:0]       cap_base,
  input  logic [AW-1:0]       cap_length,
  input  logic [AW-1:0]       cap_cursor,
  output logic                rsp_valid,
  output logic [AW-1:0]       rsp_vaddr,
  output logic                rsp_exc,
  output logic [2:0]          rsp_cause,
  output logic [CAPIDX_W-1:0] rsp_capidx
);

  localparam logic [CAPIDX_W-1:0] CAP_IDX = CAPIDX_W'(DEF_CAP_IDX);

  logic                rst_q_n;
  logic [2:0]          gate_cause;
  logic [AW-1:0]       virt_addr;
  logic                bound_fault;

  logic [2:0]          cause_d;
  logic                exc_d;
  logic [AW-1:0]       vaddr_d;
  logic [CAPIDX_W-1:0] capidx_d;
  logic                data_en;

  logic                valid_q;
  logic [AW-1:0]       vaddr_q;
  logic                exc_q;
  logic [2:0]          cause_q;
  logic [CAPIDX_W-1:0] capidx_q;

  cax_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  cax_gate_check u_gate (
    .cap_tag        (cap_tag),
    .cap_sealed     (cap_sealed),
    .cap_perm_exec  (cap_perm_exec),
    .cap_perm_load  (cap_perm_load),
    .cap_perm_store (cap_perm_store),
    .req_kind       (req_kind),
    .gate_cause     (gate_cause)
  );

  cax_bounds_check #(.AW(AW)) u_bounds (
    .req_addr    (req_addr),
    .req_width   (req_width),
    .cap_base    (cap_base),
    .cap_length  (cap_length),
    .cap_cursor  (cap_cursor),
    .virt_addr   (virt_addr),
    .bound_fault (bound_fault)
  );

  // Next state: gate causes outrank the bounds fault.
  always_comb begin
    data_en = req_valid;
    if (gate_cause != CAUSE_NONE) begin
      cause_d = gate_cause;
    end else if (bound_fault) begin
      cause_d = CAUSE_LENGTH;
    end else begin
      cause_d = CAUSE_NONE;
    end
    exc_d    = (cause_d != CAUSE_NONE);
    vaddr_d  = exc_d ? '0 : virt_addr;
    capidx_d = exc_d ? CAP_IDX : '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q  <= 1'b0;
      vaddr_q  <= '0;
      exc_q    <= 1'b0;
      cause_q  <= CAUSE_NONE;
      capidx_q <= '0;
    end else begin
      valid_q <= req_valid;
      if (data_en) begin
        vaddr_q  <= vaddr_d;
        exc_q    <= exc_d;
        cause_q  <= cause_d;
        capidx_q <= capidx_d;
      end
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_vaddr  = vaddr_q;
  assign rsp_exc    = exc_q;
  assign rsp_cause  = cause_q;
  assign rsp_capidx = capidx_q;

endmodule

// File: rtl/cax_checker.sv
module cax_checker
  import cax_pkg::*;
#(
  parameter int unsigned AW          = 64,
  parameter int unsigned CAPIDX_W    = 5,
  parameter int unsigned DEF_CAP_IDX = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_kind,
  input logic                cap_tag,
  input logic                cap_sealed,
  input logic                cap_perm_exec,
  input logic                rsp_valid,
  input logic [AW-1:0]       rsp_vaddr,
  input logic                rsp_exc,
  input logic [2:0]          rsp_cause,
  input logic [CAPIDX_W-1:0] rsp_capidx
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_vaddr) && $stable(rsp_cause) && $stable(rsp_exc)));

  a_r2_tag_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cap_tag) |=> (rsp_cause == CAUSE_TAG));

  a_r3_sealed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cap_tag && cap_sealed) |=> (rsp_cause == CAUSE_SEAL));

  a_r4_fetch_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cap_tag && !cap_sealed && req_kind == ACC_FETCH && !cap_perm_exec)
      |=> (rsp_cause == CAUSE_EXEC));

  a_r10_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc) |-> (rsp_vaddr == '0 && rsp_capidx == CAPIDX_W'(DEF_CAP_IDX)));

  a_r10_flag_matches_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_exc == (rsp_cause != CAUSE_NONE)));

  a_r9_cause_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cause <= CAUSE_LENGTH));

endmodule

bind cap_addr_xlate cax_checker #(
  .AW(AW), .CAPIDX_W(CAPIDX_W), .DEF_CAP_IDX(DEF_CAP_IDX)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .req_valid     (req_valid),
  .req_kind      (req_kind),
  .cap_tag       (cap_tag),
  .cap_sealed    (cap_sealed),
  .cap_perm_exec (cap_perm_exec),
  .rsp_valid     (rsp_valid),
  .rsp_vaddr     (rsp_vaddr),
  .rsp_exc       (rsp_exc),
  .rsp_cause     (rsp_cause),
  .rsp_capidx    (rsp_capidx)
);

// File: tb/cap_addr_xlate_tb.sv
`timescale 1ns/1ps
module cap_addr_xlate_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_addr;
  logic [1:0]  req_kind;
  logic [1:0]  req_width;
  logic        cap_tag, cap_sealed, cap_perm_exec, cap_perm_load, cap_perm_store;
  logic [63:0] cap_base, cap_length, cap_cursor;
  logic        rsp_valid;
  logic [63:0] rsp_vaddr;
  logic        rsp_exc;
  logic [2:0]  rsp_cause;
  logic [4:0]  rsp_capidx;

  int n_checks = 0;
  int n_fail   = 0;
  logic [2:0]  q_cause[$];
  logic [63:0] q_vaddr[$];

  cap_addr_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_width(req_width), .cap_tag(cap_tag),
    .cap_sealed(cap_sealed), .cap_perm_exec(cap_perm_exec),
    .cap_perm_load(cap_perm_load), .cap_perm_store(cap_perm_store),
    .cap_base(cap_base), .cap_length(cap_length), .cap_cursor(cap_cursor),
    .rsp_valid(rsp_valid), .rsp_vaddr(rsp_vaddr), .rsp_exc(rsp_exc),
    .rsp_cause(rsp_cause), .rsp_capidx(rsp_capidx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: integer arithmetic on wide values, no wrap.
  function automatic logic [2:0] ref_cause(
      input logic t, input logic s, input logic x, input logic l, input logic st,
      input logic [1:0] k, input logic [1:0] w,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] len,
      input logic [63:0] cur);
    logic [65:0] v, e, lim;
    int sz;
    if (!t) return 3'd1;
    if (s)  return 3'd2;
    if (k == 2'd0 && !x) return 3'd3;
    if (k == 2'd1 && !l) return 3'd4;
    if (k >= 2'd2 && !st) return 3'd5;
    sz  = 1 << w;
    v   = 66'(cur) + 66'(a);
    e   = v + 66'(sz);
    lim = 66'(b) + 66'(len);
    if (e > lim) return 3'd6;
    if (v < 66'(b)) return 3'd6;
    if (e > (66'd1 << 64)) return 3'd6;
    return 3'd0;
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R5";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd6: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic send(input string req, input logic [63:0] a, input logic [1:0] k,
                      input logic [1:0] w, input logic [4:0] flags,
                      input logic [63:0] b, input logic [63:0] len,
                      input logic [63:0] cur);
    logic [2:0]  ec;
    logic [63:0] ev;
    string       rq;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_width = w;
    {cap_tag, cap_sealed, cap_perm_exec, cap_perm_load, cap_perm_store} = flags;
    cap_base = b; cap_length = len; cap_cursor = cur;
    ec = ref_cause(flags[4], flags[3], flags[2], flags[1], flags[0], k, w, a, b, len, cur);
    q_cause.push_back(ec);
    q_vaddr.push_back((ec == 3'd0) ? cur + a : 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    ec = q_cause.pop_front();
    ev = q_vaddr.pop_front();
    rq = (req == "") ? tag_of(ec) : req;
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd1);
    check(rq, "cause", 64'(rsp_cause), 64'(ec));
    check(rq, "vaddr", rsp_vaddr, ev);
    check("R10", "exc", 64'(rsp_exc), 64'(ec != 3'd0));
    check("R10", "capidx", 64'(rsp_capidx), 64'd0);
  endtask

  localparam logic [4:0] ALL = 5'b10111;  // tag, unsealed, x, l, s

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = '0; req_width = '0;
    cap_tag = 0; cap_sealed = 0; cap_perm_exec = 0; cap_perm_load = 0; cap_perm_store = 0;
    cap_base = '0; cap_length = '0; cap_cursor = '0;
    repeat (3) @(negedge clk);
    check("R11", "valid in reset", 64'(rsp_valid), 64'd0);
    check("R11", "vaddr in reset", rsp_vaddr, 64'd0);
    check("R11", "cause in reset", 64'(rsp_cause), 64'd0);
    check("R11", "exc in reset", 64'(rsp_exc), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11", "valid after reset", 64'(rsp_valid), 64'd0);

    // R5 plain translation
    send("R5", 64'h10, 2'd1, 2'd3, ALL, 64'h1000, 64'h100, 64'h1000);
    // R1 idle hold with changed inputs
    @(negedge clk);
    req_addr = 64'h55; cap_tag = 1'b0;
    @(negedge clk);
    check("R1", "idle valid", 64'(rsp_valid), 64'd0);
    check("R1", "idle vaddr held", rsp_vaddr, 64'h1010);
    check("R1", "idle cause held", 64'(rsp_cause), 64'd0);

    // R6 upper bound edges and sizes
    send("R6", 64'hF8, 2'd1, 2'd3, ALL, 64'h1000, 64'h100, 64'h1000);
    send("R6", 64'hF9, 2'd1, 2'd3, ALL, 64'h1000, 64'h100, 64'h1000);
    send("R6", 64'hFF, 2'd2, 2'd0, ALL, 64'h1000, 64'h100, 64'h1000);
    send("R6", 64'hFF, 2'd2, 2'd1, ALL, 64'h1000, 64'h100, 64'h1000);
    send("R6", 64'hFC, 2'd0, 2'd2, ALL, 64'h1000, 64'h100, 64'h1000);
    send("R6", 64'hFD, 2'd0, 2'd2, ALL, 64'h1000, 64'h100, 64'h1000);
    // R7 lower bound
    send("R7", 64'h0, 2'd1, 2'd0, ALL, 64'h1000, 64'h100, 64'hFFF);
    send("R7", 64'h1, 2'd1, 2'd0, ALL, 64'h1000, 64'h100, 64'hFFF);
    // R8 end beyond 2^64 with a limit above it
    send("R8", 64'h0, 2'd1, 2'd3, ALL, 64'hFFFF_FFFF_FFFF_F000, 64'h2000,
         64'hFFFF_FFFF_FFFF_FFF8);
    send("R8", 64'h4, 2'd1, 2'd3, ALL, 64'hFFFF_FFFF_FFFF_F000, 64'h2000,
         64'hFFFF_FFFF_FFFF_FFF8);
    send("R8", 64'h100, 2'd1, 2'd0, ALL, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
         64'hFFFF_FFFF_FFFF_FF00);
    // R4 permissions per kind
    send("R4", 64'h10, 2'd0, 2'd2, 5'b10011, 64'h1000, 64'h100, 64'h1000);
    send("R4", 64'h10, 2'd0, 2'd2, 5'b10100, 64'h1000, 64'h100, 64'h1000);
    send("R4", 64'h10, 2'd1, 2'd2, 5'b10101, 64'h1000, 64'h100, 64'h1000);
    send("R4", 64'h10, 2'd2, 2'd2, 5'b10110, 64'h1000, 64'h100, 64'h1000);
    send("R4", 64'h10, 2'd3, 2'd2, 5'b10110, 64'h1000, 64'h100, 64'h1000);
    send("R4", 64'h10, 2'd3, 2'd2, 5'b10001, 64'h1000, 64'h100, 64'h1000);
    // R2, R3, R9 priority
    send("R2", 64'h10, 2'd1, 2'd2, 5'b00111, 64'h1000, 64'h100, 64'h1000);
    send("R9", 64'hFFFF, 2'd2, 2'd3, 5'b01000, 64'h1000, 64'h100, 64'h1000);
    send("R3", 64'h10, 2'd1, 2'd2, 5'b11111, 64'h1000, 64'h100, 64'h1000);
    send("R9", 64'hFFFF, 2'd2, 2'd3, 5'b11000, 64'h1000, 64'h100, 64'h1000);
    send("R9", 64'hFFFF, 2'd1, 2'd3, 5'b10110, 64'h1000, 64'h100, 64'h1000);

    // Mixed patterns near the bounds
    for (int i = 0; i < 400; i++) begin
      logic [63:0] b, len, cur, a;
      logic [4:0]  f;
      b   = {$urandom, $urandom};
      len = 64'($urandom_range(0, 64));
      cur = b - 64'($urandom_range(0, 8));
      a   = 64'($urandom_range(0, 72));
      f   = ($urandom_range(0, 3) == 0) ? 5'($urandom) : ALL;
      if (i % 50 == 0) begin
        b = 64'hFFFF_FFFF_FFFF_FFC0; len = 64'h80; cur = b;
      end
      send("", a, 2'($urandom), 2'($urandom), f, b, len, cur);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule